// File: doc/BRIEF.md
# Programmable Address Decode Windows

This block steers 32-bit bus addresses into a DRAM target through a small set of programmable windows. Software programs each window through a plain register port with address, write data, write enable and combinational read data. Each window has three registers. The control register holds the enable, target, attribute and size fields. The base register holds the window start. An optional remap register holds the translated start.

Every cycle the block compares the lookup address against all windows in parallel. Base and size use 64 KB granularity. Size is stored as the unit count minus one. The block reports the following one cycle later:
- whether a window matched,
- which window matched (the lowest-numbered one wins),
- that window's target and attribute fields,
- the translated address.

Only the lowest-numbered windows own a remap register. All other windows pass the address through unchanged.

Top module: `addr_win_decoder`

## Requirements
- R1: After reset every register reads zero and the decode outputs are hit=0, index=0, target=0 and attribute=0.
- R2: The register group of window w starts at byte address w*STRIDE. The control register sits at offset 0x0 and has these fields: bit 0 is enable, bits [7:4] are target, bits [15:8] are attribute and bits [31:16] are size, coded as (bytes/64 KB)-1. Bits [3:1] read back zero.
- R3: The base register sits at offset 0x4 and holds base/64 KB in bits [31:16]. Bits [15:0] read back zero.
- R4: The remap register sits at offset 0x8 and exists only for windows below NUM_REMAP. For the other windows it reads zero and ignores writes.
- R5: A window whose enable bit is clear never matches.
- R6: An address matches an enabled window when (addr[31:16]-base) mod 2^16 <= size. This means a window can wrap past the top of the address space.
- R7: When several enabled windows match, the lowest-numbered one is reported.
- R8: When no window matches, hit=0, index=0, target=0 and attribute=0, and the translated address equals the lookup address.
- R9: For a matching window that has remap, the translated address is {remap + (addr[31:16]-base), addr[15:0]}, with the upper sum taken modulo 2^16.
- R10: For a matching window without remap, the translated address equals the lookup address.
- R11: A window with base 0 and size 0xFFFF matches every address.
- R12: The decode outputs reflect the lookup address of the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | REG_AW | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_we | input | 1 | Register write enable |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| lk_addr | input | 32 | Lookup address |
| hit_o | output | 1 | A window matched |
| idx_o | output | IDX_W | Index of the winning window |
| target_o | output | 4 | Target field of the winner |
| attr_o | output | 8 | Attribute field of the winner |
| xlat_o | output | 32 | Translated address |

## Verification
The bench builds the block with four windows, two of which carry remap, and a 16-byte register stride. This mix exercises remap translation and pass-through side by side. It also lets one window be placed so that it wraps past 0xFFFF and lets two windows overlap so that priority decides. The fourth window is held disabled first and enabled later, which tests the enable gate and a single-unit (64 KB) window. The remap write to window 2 falls on a window without remap, so that write must be ignored.

// File: rtl/awd_pkg.sv
package awd_pkg;
    localparam int TGT_W  = 4;
    localparam int ATTR_W = 8;
    localparam int GRAN_W = 16;

    typedef struct packed {
        logic              en;
        logic [TGT_W-1:0]  tgt;
        logic [ATTR_W-1:0] attr;
        logic [GRAN_W-1:0] size;
        logic [GRAN_W-1:0] base;
        logic [GRAN_W-1:0] remap;
    } win_cfg_t;
endpackage

// File: rtl/awd_regfile.sv
module awd_regfile
    import awd_pkg::*;
#(
    parameter int NUM_WIN   = 4,
    parameter int NUM_REMAP = 2,
    parameter int STRIDE_LG = 4,
    parameter int REG_AW    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic              reg_we,
    output logic [31:0]       reg_rdata,
    output win_cfg_t          cfg [NUM_WIN]
);
    localparam int WSEL_W = REG_AW - STRIDE_LG;
    localparam logic [STRIDE_LG-1:0] OFF_CTRL  = STRIDE_LG'(0);
    localparam logic [STRIDE_LG-1:0] OFF_BASE  = STRIDE_LG'(4);
    localparam logic [STRIDE_LG-1:0] OFF_REMAP = STRIDE_LG'(8);

    win_cfg_t cfg_d [NUM_WIN];
    win_cfg_t cfg_q [NUM_WIN];

    logic [WSEL_W-1:0]    sel_win;
    logic [STRIDE_LG-1:0] sel_off;
    logic                 unused_wbits;

    assign sel_win      = reg_addr[REG_AW-1:STRIDE_LG];
    assign sel_off      = reg_addr[STRIDE_LG-1:0];
    assign unused_wbits = ^reg_wdata[3:1];

    always_comb begin
        cfg_d     = cfg_q;
        reg_rdata = '0;
        for (int w = 0; w < NUM_WIN; w++) begin
            if (sel_win == WSEL_W'(w)) begin
                if (reg_we) begin
                    case (sel_off)
                        OFF_CTRL: begin
                            cfg_d[w].en   = reg_wdata[0];
                            cfg_d[w].tgt  = reg_wdata[7:4];
                            cfg_d[w].attr = reg_wdata[15:8];
                            cfg_d[w].size = reg_wdata[31:16];
                        end
                        OFF_BASE:  cfg_d[w].base  = reg_wdata[31:16];
                        OFF_REMAP: cfg_d[w].remap = reg_wdata[31:16];
                        default: ;
                    endcase
                end
                case (sel_off)
                    OFF_CTRL:  reg_rdata = {cfg_q[w].size, cfg_q[w].attr,
                                            cfg_q[w].tgt, 3'b000, cfg_q[w].en};
                    OFF_BASE:  reg_rdata = {cfg_q[w].base, 16'h0000};
                    OFF_REMAP: reg_rdata = {cfg_q[w].remap, 16'h0000};
                    default:   reg_rdata = '0;
                endcase
            end
            if (w >= NUM_REMAP) begin
                cfg_d[w].remap = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < NUM_WIN; w++) begin
                cfg_q[w] <= '0;
            end
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/awd_match.sv
module awd_match
    import awd_pkg::*;
#(
    parameter int NUM_WIN = 4
) (
    input  logic [GRAN_W-1:0] addr_hi,
    input  win_cfg_t          cfg     [NUM_WIN],
    output logic [NUM_WIN-1:0] hit_vec,
    output logic [GRAN_W-1:0] diff    [NUM_WIN]
);
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        logic [GRAN_W-1:0] delta;
        assign delta      = addr_hi - cfg[w].base;
        assign diff[w]    = delta;
        assign hit_vec[w] = cfg[w].en && (delta <= cfg[w].size);
    end
endmodule

// File: rtl/awd_select.sv
module awd_select
    import awd_pkg::*;
#(
    parameter int NUM_WIN   = 4,
    parameter int NUM_REMAP = 2,
    parameter int IDX_W     = 2
) (
    input  logic [31:0]        addr,
    input  win_cfg_t           cfg     [NUM_WIN],
    input  logic [NUM_WIN-1:0] hit_vec,
    input  logic [GRAN_W-1:0]  diff    [NUM_WIN],
    output logic               hit,
    output logic [IDX_W-1:0]   idx,
    output logic [TGT_W-1:0]   tgt,
    output logic [ATTR_W-1:0]  attr,
    output logic [31:0]        xlat
);
    always_comb begin
        hit  = 1'b0;
        idx  = '0;
        tgt  = '0;
        attr = '0;
        xlat = addr;
        for (int w = NUM_WIN - 1; w >= 0; w--) begin
            if (hit_vec[w]) begin
                hit  = 1'b1;
                idx  = IDX_W'(w);
                tgt  = cfg[w].tgt;
                attr = cfg[w].attr;
                if (w < NUM_REMAP) begin
                    xlat = {cfg[w].remap + diff[w], addr[15:0]};
                end else begin
                    xlat = addr;
                end
            end
        end
    end
endmodule

// File: rtl/addr_win_decoder.sv
module addr_win_decoder
    import awd_pkg::*;
#(
    parameter int NUM_WIN   = 4,
    parameter int NUM_REMAP = 2,
    parameter int STRIDE    = 16,
    parameter int STRIDE_LG = $clog2(STRIDE),
    parameter int REG_AW    = $clog2(NUM_WIN * STRIDE) + 1,
    parameter int IDX_W     = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic              reg_we,
    output logic [31:0]       reg_rdata,
    input  logic [31:0]       lk_addr,
    output logic              hit_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic [3:0]        target_o,
    output logic [7:0]        attr_o,
    output logic [31:0]       xlat_o
);
    typedef struct packed {
        logic              hit;
        logic [IDX_W-1:0]  idx;
        logic [TGT_W-1:0]  tgt;
        logic [ATTR_W-1:0] attr;
        logic [31:0]       xlat;
    } dec_out_t;

    win_cfg_t           cfg     [NUM_WIN];
    logic [NUM_WIN-1:0] hit_vec;
    logic [GRAN_W-1:0]  diff    [NUM_WIN];
    logic [NUM_WIN-1:0] win_en;
    dec_out_t           out_d, out_q;

    awd_regfile #(
        .NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP),
        .STRIDE_LG(STRIDE_LG), .REG_AW(REG_AW)
    ) i_regs (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata), .cfg(cfg)
    );

    awd_match #(.NUM_WIN(NUM_WIN)) i_match (
        .addr_hi(lk_addr[31:16]), .cfg(cfg), .hit_vec(hit_vec), .diff(diff)
    );

    awd_select #(.NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP), .IDX_W(IDX_W)) i_sel (
        .addr(lk_addr), .cfg(cfg), .hit_vec(hit_vec), .diff(diff),
        .hit(out_d.hit), .idx(out_d.idx), .tgt(out_d.tgt),
        .attr(out_d.attr), .xlat(out_d.xlat)
    );

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_en
        assign win_en[w] = cfg[w].en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign hit_o    = out_q.hit;
    assign idx_o    = out_q.idx;
    assign target_o = out_q.tgt;
    assign attr_o   = out_q.attr;
    assign xlat_o   = out_q.xlat;
endmodule

// File: rtl/awd_checker.sv
module awd_checker #(
    parameter int NUM_WIN   = 4,
    parameter int NUM_REMAP = 2,
    parameter int STRIDE_LG = 4,
    parameter int REG_AW    = 8,
    parameter int IDX_W     = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic [REG_AW-1:0]  reg_addr,
    input logic [31:0]        reg_rdata,
    input logic [31:0]        lk_addr,
    input logic               hit_o,
    input logic [IDX_W-1:0]   idx_o,
    input logic [3:0]         target_o,
    input logic [7:0]         attr_o,
    input logic [31:0]        xlat_o,
    input logic [NUM_WIN-1:0] win_en
);
    localparam int WSEL_W = REG_AW - STRIDE_LG;

    assert_miss_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_o |-> (idx_o == '0 && target_o == '0 && attr_o == '0
                    && xlat_o == $past(lk_addr)));

    assert_hit_enabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> ((($past(win_en) >> idx_o) & NUM_WIN'(1)) != '0));

    assert_passthru_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o && int'(idx_o) >= NUM_REMAP) |-> (xlat_o == $past(lk_addr)));

    assert_low_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
        xlat_o[15:0] == $past(lk_addr[15:0]));

    assert_no_remap_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr[STRIDE_LG-1:0] == STRIDE_LG'(8)
         && reg_addr[REG_AW-1:STRIDE_LG] >= WSEL_W'(NUM_REMAP)) |-> (reg_rdata == '0));
endmodule

bind addr_win_decoder awd_checker #(
    .NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP), .STRIDE_LG(STRIDE_LG),
    .REG_AW(REG_AW), .IDX_W(IDX_W)
) i_awd_checker (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
    .lk_addr(lk_addr), .hit_o(hit_o), .idx_o(idx_o), .target_o(target_o),
    .attr_o(attr_o), .xlat_o(xlat_o), .win_en(win_en)
);

// File: tb/test_addr_win_decoder.sv
`timescale 1ns/1ps
module test_addr_win_decoder;
    localparam int NUM_WIN = 4, NUM_REMAP = 2, STRIDE = 16;
    localparam int REG_AW = 7, IDX_W = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [REG_AW-1:0] reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic              reg_we = 1'b0;
    logic [31:0]       reg_rdata;
    logic [31:0]       lk_addr = '0;
    logic              hit_o;
    logic [IDX_W-1:0]  idx_o;
    logic [3:0]        target_o;
    logic [7:0]        attr_o;
    logic [31:0]       xlat_o;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    addr_win_decoder #(.NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP), .STRIDE(STRIDE)) i_addr_win_decoder (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata), .lk_addr(lk_addr), .hit_o(hit_o),
        .idx_o(idx_o), .target_o(target_o), .attr_o(attr_o), .xlat_o(xlat_o)
    );

    localparam int NV = 10;
    localparam logic [31:0] V_ADDR [NV] = '{32'h1012_3456, 32'h1080_ABCD, 32'h1100_0001,
        32'h2080_0000, 32'h207F_FFFF, 32'hFFF5_1234, 32'h000F_0000, 32'h0010_0000,
        32'h4000_0000, 32'h0FFF_FFFF};
    localparam logic V_HIT [NV] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0};
    localparam logic [1:0] V_IDX [NV] = '{2'd0, 2'd0, 2'd1, 2'd0, 2'd1, 2'd2, 2'd2, 2'd0, 2'd0, 2'd0};
    localparam logic [3:0] V_TGT [NV] = '{4'd1, 4'd1, 4'd2, 4'd0, 4'd2, 4'd3, 4'd3, 4'd0, 4'd0, 4'd0};
    localparam logic [7:0] V_ATTR [NV] = '{8'h0E, 8'h0E, 8'h1D, 8'h00, 8'h1D, 8'h3C, 8'h3C,
        8'h00, 8'h00, 8'h00};
    localparam logic [31:0] V_XLAT [NV] = '{32'h8012_3456, 32'h8080_ABCD, 32'h2080_0001,
        32'h2080_0000, 32'h2FFF_FFFF, 32'hFFF5_1234, 32'h000F_0000, 32'h0010_0000,
        32'h4000_0000, 32'h0FFF_FFFF};
    localparam string V_REQ [NV] = '{"R9", "R7", "R9", "R6", "R6", "R10", "R6", "R8", "R5", "R8"};

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic wr(input int win, input int off, input logic [31:0] d);
        @(negedge clk);
        reg_addr = REG_AW'(win * STRIDE + off);
        reg_wdata = d;
        reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input int win, input int off, output logic [31:0] d);
        @(negedge clk);
        reg_addr = REG_AW'(win * STRIDE + off);
        #1;
        d = reg_rdata;
    endtask

    task automatic lookup(input logic [31:0] a);
        @(negedge clk);
        lk_addr = a;
        @(negedge clk);
    endtask

    task automatic chk_out(input string req, input logic h, input logic [1:0] i,
                           input logic [3:0] t, input logic [7:0] at, input logic [31:0] x);
        chk({req, " hit"}, 32'(hit_o), 32'(h));
        chk({req, " idx"}, 32'(idx_o), 32'(i));
        chk({req, " target"}, 32'(target_o), 32'(t));
        chk({req, " attr"}, 32'(attr_o), 32'(at));
        chk({req, " xlat"}, xlat_o, x);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk_out("R1", 1'b0, 2'd0, 4'd0, 8'h00, 32'h0);
        rd(0, 0, r); chk("R1 ctrl0", r, 32'h0);
        rd(1, 8, r); chk("R1 remap1", r, 32'h0);
        rst_n = 1'b1;

        wr(0, 0, 32'h00FF_0E1F);
        wr(0, 4, 32'h1000_ABCD);
        wr(0, 8, 32'h8000_0000);
        wr(1, 0, 32'h0FFF_1D21);
        wr(1, 4, 32'h1080_0000);
        wr(1, 8, 32'h2000_0000);
        wr(2, 0, 32'h001F_3C31);
        wr(2, 4, 32'hFFF0_0000);
        wr(2, 8, 32'h7777_0000);
        wr(3, 0, 32'h0000_0550);
        wr(3, 4, 32'h4000_0000);

        rd(0, 0, r); chk("R2 ctrl fields", r, 32'h00FF_0E11);
        rd(0, 4, r); chk("R3 base low zero", r, 32'h1000_0000);
        rd(0, 8, r); chk("R4 remap0", r, 32'h8000_0000);
        rd(2, 8, r); chk("R4 remap ignored", r, 32'h0);
        rd(3, 0, r); chk("R2 ctrl3", r, 32'h0000_0550);

        for (int v = 0; v < NV; v++) begin
            lookup(V_ADDR[v]);
            chk_out(V_REQ[v], V_HIT[v], V_IDX[v], V_TGT[v], V_ATTR[v], V_XLAT[v]);
        end

        // R10: single-unit window without remap
        wr(3, 0, 32'h0000_0551);
        lookup(32'h4000_1111);
        chk_out("R10", 1'b1, 2'd3, 4'd5, 8'h05, 32'h4000_1111);
        lookup(32'h4001_0000);
        chk_out("R6 size0 end", 1'b0, 2'd0, 4'd0, 8'h00, 32'h4001_0000);

        // R12: one cycle of latency
        lookup(32'h1012_3456);
        @(negedge clk);
        lk_addr = 32'h4000_2222;
        #1;
        chk("R12 before edge", xlat_o, 32'h8012_3456);
        @(negedge clk);
        chk("R12 after edge", xlat_o, 32'h4000_2222);

        // R5: clearing control disables window 0
        wr(0, 0, 32'h0);
        lookup(32'h1012_3456);
        chk_out("R5", 1'b0, 2'd0, 4'd0, 8'h00, 32'h1012_3456);

        // R11: full window, and R7 priority over window 1
        wr(0, 4, 32'h0);
        wr(0, 0, 32'hFFFF_0011);
        lookup(32'hDEAD_BEEF);
        chk_out("R11", 1'b1, 2'd0, 4'd1, 8'h00, 32'h5EAD_BEEF);
        lookup(32'h0000_0000);
        chk_out("R11 zero", 1'b1, 2'd0, 4'd1, 8'h00, 32'h8000_0000);
        lookup(32'h1100_0001);
        chk_out("R7", 1'b1, 2'd0, 4'd1, 8'h00, 32'h9100_0001);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule